// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a register front end and the byte engine of an I2C master. Software pushes 11-bit command words into a transmit queue. Each word carries one of two things: a byte to send, or a request to read one byte. Each word also carries a STOP flag and a repeated-START flag. The byte engine pops the words in order and sees each one already decoded. Bytes that the engine receives go into a second queue, and software drains that queue through the same data register.

Both queues have a fill level that software can read. Software takes depth minus level as the free space. Two threshold registers drive a transmit-low indication and a receive-high indication. An enable bit starts the block and stops it. A separate status bit shows whether the block is really enabled, and that bit drops only once the engine reports idle. Either queue can be flushed in one cycle. This happens when the engine signals an abort, and also when software pushes a word while the block is disabled, which records a disabled-master abort cause. The block also holds the target address and a mode bit that selects 7-bit or 10-bit addressing, for the engine to use.

Register map (3-bit word address `reg_addr_i`, 11-bit data). Fields not listed read as 0.
- 0: control. bit0 = enable, bit1 = 10-bit address mode.
- 1: target address, bits 9:0.
- 2: data. A write pushes a command word. A read pops one receive byte.
- 3: transmit level.
- 4: receive level.
- 5: thresholds. The transmit threshold is in bits LW-1:0 and the receive threshold is in bits 2*LW-1:LW, where LW = clog2(DEPTH+1), which is 4 by default.
- 6: status. bit0 = enable status, bit1 = transmit-low, bit2 = receive-high, bit3 = transmit overflow, bit4 = receive underflow, bit5 = engine abort, bit6 = disabled-push abort. Writing a 1 to any of bits 3 to 6 clears that bit.

Top module: `i2cm_cmdq`

## Requirements
- R1: A command word is decoded at the engine outputs, head of the queue first:
  - bit 8 set means read, and `cmd_read_o` is 1;
  - bit 9 drives `cmd_stop_o`;
  - bit 10 drives `cmd_restart_o`;
  - for a write, `cmd_byte_o` equals bits 7:0;
  - for a read, `cmd_byte_o` is 0, whatever the data bits hold.
- R2: Words leave the transmit queue in the order they were pushed. Registers 3 and 4 read the transmit and receive fill levels. Each level can count from 0 up to DEPTH.
- R3: A push to a full transmit queue drops the word, leaves the level at DEPTH and sets status bit 3.
- R4: A read of register 2 while the receive queue is empty returns 0 and sets status bit 4.
- R5: `tx_low_o` (status bit 1) is 1 exactly when the transmit level is less than or equal to the transmit threshold.
- R6: `rx_high_o` (status bit 2) is 1 exactly when the receive level is greater than the receive threshold. A threshold of 0 therefore means one entry.
- R7: A one-cycle pulse on `eng_abort_i` empties both queues by the next cycle and sets status bit 5.
- R8: Enable status (bit 0 and `en_status_o`) behaves as follows:
  - it rises one cycle after the enable bit is set;
  - after the enable bit is cleared, it falls only in a cycle where `eng_busy_i` is 0;
  - while it is 0, `cmd_valid_o` is 0 even if the transmit queue is not empty.
- R9: A push to register 2 while the enable status is 0 drops the word, flushes both queues, and sets status bit 6.
- R10: Register 1 drives `target_addr_o`, and control bit 1 drives `addr_10bit_o`.
- R11: `abort_o` is the OR of status bits 5 and 6. Writing 1s to status bits 3 to 6 clears the flags written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops receive data at address 2) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 11 | Register write data |
| reg_rdata_o | output | 11 | Register read data (combinational) |
| cmd_valid_o | output | 1 | Command word available for the engine |
| cmd_pop_i | input | 1 | Engine consumes the head command |
| cmd_byte_o | output | 8 | Byte to send (0 for reads) |
| cmd_read_o | output | 1 | Head command is a read request |
| cmd_stop_o | output | 1 | STOP after this byte |
| cmd_restart_o | output | 1 | Repeated START before this byte |
| target_addr_o | output | 10 | Target address |
| addr_10bit_o | output | 1 | 10-bit addressing mode |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| eng_abort_i | input | 1 | Engine abort, flushes both queues |
| eng_busy_i | input | 1 | Engine is mid-transfer |
| tx_low_o | output | 1 | Transmit level at or below threshold |
| rx_high_o | output | 1 | Receive level above threshold |
| en_status_o | output | 1 | Real enable state |
| abort_o | output | 1 | An abort cause is pending |

## Verification
A corrupted pointer or level counter shows up at the engine outputs, because the next popped command carries the wrong byte or the wrong flags. It also shows up at the level registers and threshold indications in the cycle after the faulty update. A flush that fails to clear both queues is visible in the next cycle's levels. An enable status that drops too early lets `cmd_valid_o` fall while the engine still reports busy. That can be seen within a cycle of releasing the enable bit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int CMD_W  = 11;
    localparam int BYTE_W = 8;
    localparam int TAR_W  = 10;

    // Command word layout: restart is bit 10, stop is bit 9, read is bit 8.
    typedef struct packed {
        logic              restart;
        logic              stop;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_TARGET = 3'd1;
    localparam logic [2:0] A_DATA   = 3'd2;
    localparam logic [2:0] A_TXLVL  = 3'd3;
    localparam logic [2:0] A_RXLVL  = 3'd4;
    localparam logic [2:0] A_THRESH = 3'd5;
    localparam logic [2:0] A_STATUS = 3'd6;

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    input  logic                       flush_i,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       full_o,
    output logic                       empty_o
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           lvl;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_i && (s_q.lvl != '0);
        do_push = push_i && ((s_q.lvl != LW'(DEPTH)) || do_pop);
        if (flush_i) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.lvl = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = wdata_i;
                s_d.wp          = ptr_inc(s_q.wp);
            end
            if (do_pop) begin
                s_d.rp = ptr_inc(s_q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.lvl = s_q.lvl + 1'b1;
                2'b01:   s_d.lvl = s_q.lvl - 1'b1;
                default: s_d.lvl = s_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_o  = s_q.mem[s_q.rp];
    assign level_o = s_q.lvl;
    assign full_o  = (s_q.lvl == LW'(DEPTH));
    assign empty_o = (s_q.lvl == '0);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lvl <= LW'(DEPTH))); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (level_o == '0)); // R7

endmodule

// File: rtl/i2cm_thresh.sv
module i2cm_thresh #(
    parameter int LW = 4
) (
    input  logic [LW-1:0] tx_lvl_i,
    input  logic [LW-1:0] tx_thr_i,
    input  logic [LW-1:0] rx_lvl_i,
    input  logic [LW-1:0] rx_thr_i,
    output logic          tx_low_o,
    output logic          rx_high_o
);
    always_comb begin
        tx_low_o  = (tx_lvl_i <= tx_thr_i);
        rx_high_o = (rx_lvl_i >  rx_thr_i);
    end
endmodule

// File: rtl/i2cm_cmdq.sv
module i2cm_cmdq
    import i2cm_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [CMD_W-1:0]  reg_wdata_i,
    output logic [CMD_W-1:0]  reg_rdata_o,
    output logic              cmd_valid_o,
    input  logic              cmd_pop_i,
    output logic [BYTE_W-1:0] cmd_byte_o,
    output logic              cmd_read_o,
    output logic              cmd_stop_o,
    output logic              cmd_restart_o,
    output logic [TAR_W-1:0]  target_addr_o,
    output logic              addr_10bit_o,
    input  logic              rx_push_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              eng_abort_i,
    input  logic              eng_busy_i,
    output logic              tx_low_o,
    output logic              rx_high_o,
    output logic              en_status_o,
    output logic              abort_o
);
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             enable;
        logic             mode10;
        logic [TAR_W-1:0] tar;
        logic [LW-1:0]    tx_thr;
        logic [LW-1:0]    rx_thr;
        logic             en_stat;
        logic             tx_over;
        logic             rx_under;
        logic             ab_eng;
        logic             ab_dis;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_ctrl, wr_tar, wr_thr, wr_stat, push_req, pop_req;
    logic              dis_push, flush, tx_push, tx_pop, rx_pop;
    logic [CMD_W-1:0]  tx_head;
    logic [BYTE_W-1:0] rx_head;
    logic [LW-1:0]     tx_level, rx_level;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    cmd_t              head;

    always_comb begin
        wr_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);
        wr_tar   = reg_wr_i && (reg_addr_i == A_TARGET);
        wr_thr   = reg_wr_i && (reg_addr_i == A_THRESH);
        wr_stat  = reg_wr_i && (reg_addr_i == A_STATUS);
        push_req = reg_wr_i && (reg_addr_i == A_DATA);
        pop_req  = reg_rd_i && (reg_addr_i == A_DATA);
        dis_push = push_req && !ctl_q.en_stat;
        flush    = eng_abort_i || dis_push;
        tx_push  = push_req && ctl_q.en_stat && !tx_full;
        tx_pop   = cmd_pop_i && cmd_valid_o;
        rx_pop   = pop_req && !rx_empty;
    end

    i2cm_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_i(tx_push), .wdata_i(reg_wdata_i),
        .pop_i(tx_pop), .flush_i(flush),
        .head_o(tx_head), .level_o(tx_level),
        .full_o(tx_full), .empty_o(tx_empty)
    );

    i2cm_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_push_i), .wdata_i(rx_data_i),
        .pop_i(rx_pop), .flush_i(flush),
        .head_o(rx_head), .level_o(rx_level),
        .full_o(rx_full), .empty_o(rx_empty)
    );

    i2cm_thresh #(.LW(LW)) u_thr (
        .tx_lvl_i(tx_level), .tx_thr_i(ctl_q.tx_thr),
        .rx_lvl_i(rx_level), .rx_thr_i(ctl_q.rx_thr),
        .tx_low_o(tx_low_o), .rx_high_o(rx_high_o)
    );

    // Next-state of control and status
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.enable = reg_wdata_i[0];
            ctl_d.mode10 = reg_wdata_i[1];
        end
        if (wr_tar) ctl_d.tar = reg_wdata_i[TAR_W-1:0];
        if (wr_thr) begin
            ctl_d.tx_thr = reg_wdata_i[LW-1:0];
            ctl_d.rx_thr = reg_wdata_i[2*LW-1:LW];
        end
        if (ctl_q.enable)     ctl_d.en_stat = 1'b1;
        else if (!eng_busy_i) ctl_d.en_stat = 1'b0;
        if (wr_stat) begin
            if (reg_wdata_i[3]) ctl_d.tx_over  = 1'b0;
            if (reg_wdata_i[4]) ctl_d.rx_under = 1'b0;
            if (reg_wdata_i[5]) ctl_d.ab_eng   = 1'b0;
            if (reg_wdata_i[6]) ctl_d.ab_dis   = 1'b0;
        end
        if (push_req && ctl_q.en_stat && tx_full) ctl_d.tx_over  = 1'b1;
        if (pop_req && rx_empty)                  ctl_d.rx_under = 1'b1;
        if (eng_abort_i)                          ctl_d.ab_eng   = 1'b1;
        if (dis_push)                             ctl_d.ab_dis   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Engine-side decode
    always_comb begin
        head          = cmd_t'(tx_head);
        cmd_valid_o   = ctl_q.en_stat && !tx_empty;
        cmd_read_o    = head.rd;
        cmd_stop_o    = head.stop;
        cmd_restart_o = head.restart;
        cmd_byte_o    = head.rd ? '0 : head.data;
    end

    // Register read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_CTRL:   reg_rdata_o = CMD_W'({ctl_q.mode10, ctl_q.enable});
            A_TARGET: reg_rdata_o = CMD_W'(ctl_q.tar);
            A_DATA:   reg_rdata_o = rx_empty ? '0 : CMD_W'(rx_head);
            A_TXLVL:  reg_rdata_o = CMD_W'(tx_level);
            A_RXLVL:  reg_rdata_o = CMD_W'(rx_level);
            A_THRESH: reg_rdata_o = CMD_W'({ctl_q.rx_thr, ctl_q.tx_thr});
            A_STATUS: reg_rdata_o = CMD_W'({ctl_q.ab_dis, ctl_q.ab_eng, ctl_q.rx_under,
                                            ctl_q.tx_over, rx_high_o, tx_low_o,
                                            ctl_q.en_stat});
            default:  reg_rdata_o = '0;
        endcase
    end

    assign target_addr_o = ctl_q.tar;
    assign addr_10bit_o  = ctl_q.mode10;
    assign en_status_o   = ctl_q.en_stat;
    assign abort_o       = ctl_q.ab_eng | ctl_q.ab_dis;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && ctl_q.en_stat && tx_full && !tx_pop && !eng_abort_i)
        |=> ((tx_level == $past(tx_level)) && ctl_q.tx_over)); // R3
    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && rx_empty) |-> (reg_rdata_o == '0)); // R4
    AST_RX_THR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.rx_thr == '0) && !rx_empty) |-> rx_high_o); // R6
    AST_EN_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.en_stat) |-> (!$past(eng_busy_i) && !$past(ctl_q.enable))); // R8
    AST_DIS_PUSH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        dis_push |=> (ctl_q.ab_dis && (tx_level == '0) && (rx_level == '0))); // R9

endmodule

// File: tb/sim_i2cm_cmdq.sv
module sim_i2cm_cmdq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [10:0] reg_wdata = 0;
    logic [10:0] reg_rdata;
    logic        cmd_valid, cmd_pop = 0;
    logic [7:0]  cmd_byte;
    logic        cmd_read, cmd_stop, cmd_restart;
    logic [9:0]  target_addr;
    logic        addr_10bit;
    logic        rx_push = 0;
    logic [7:0]  rx_data = 0;
    logic        eng_abort = 0, eng_busy = 0;
    logic        tx_low, rx_high, en_status, abort_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    i2cm_cmdq #(.DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .cmd_valid_o(cmd_valid), .cmd_pop_i(cmd_pop), .cmd_byte_o(cmd_byte),
        .cmd_read_o(cmd_read), .cmd_stop_o(cmd_stop), .cmd_restart_o(cmd_restart),
        .target_addr_o(target_addr), .addr_10bit_o(addr_10bit),
        .rx_push_i(rx_push), .rx_data_i(rx_data),
        .eng_abort_i(eng_abort), .eng_busy_i(eng_busy),
        .tx_low_o(tx_low), .rx_high_o(rx_high),
        .en_status_o(en_status), .abort_o(abort_o)
    );

    // {word[10:0], byte[7:0], read, stop, restart}
    localparam logic [21:0] VEC [6] = '{
        {11'h0A5, 8'hA5, 3'b000},
        {11'h43C, 8'h3C, 3'b001},
        {11'h1FF, 8'h00, 3'b100},
        {11'h300, 8'h00, 3'b110},
        {11'h5E7, 8'h00, 3'b101},
        {11'h2C3, 8'hC3, 3'b010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [10:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [10:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rxput(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1; rx_data = d;
        @(negedge clk);
        rx_push = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk("R8 reset en_status", en_status, 0);
        chk("R8 reset cmd_valid", cmd_valid, 0);
        chk("R5 reset tx_low", tx_low, 1);
        chk("R6 reset rx_high", rx_high, 0);
        chk("R11 reset abort", abort_o, 0);
        rd(3'd3, v); chk("R2 reset tx level", v, 0);

        // R10 target and mode, R8 enable rise
        wr(3'd1, 11'h2A5);
        wr(3'd0, 11'h003);
        chk("R10 target", target_addr, 10'h2A5);
        chk("R10 mode10", addr_10bit, 1);
        rd(3'd6, v); chk("R8 enable status bit", v[0], 1);

        // R2 fill
        for (int i = 0; i < 6; i++) wr(3'd2, VEC[i][21:11]);
        rd(3'd3, v); chk("R2 tx level 6", v, 6);
        // R5 thresholds
        chk("R5 tx_low thr0 lvl6", tx_low, 0);
        wr(3'd5, 11'h006);
        chk("R5 tx_low thr6 lvl6", tx_low, 1);
        wr(3'd5, 11'h005);
        chk("R5 tx_low thr5 lvl6", tx_low, 0);
        rd(3'd6, v); chk("R5 status bit1", v[1], 0);
        wr(3'd5, 11'h000);

        // R1 decode in order
        eng_busy = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R1 valid", cmd_valid, 1);
            chk("R1 byte", cmd_byte, VEC[i][10:3]);
            chk("R1 read", cmd_read, VEC[i][2]);
            chk("R1 stop", cmd_stop, VEC[i][1]);
            chk("R1 restart", cmd_restart, VEC[i][0]);
            cmd_pop = 1;
            @(negedge clk);
            cmd_pop = 0;
        end
        chk("R2 valid after drain", cmd_valid, 0);

        // R3 overflow
        for (int i = 0; i < 9; i++) wr(3'd2, 11'(i + 16));
        rd(3'd3, v); chk("R3 level at depth", v, 8);
        rd(3'd6, v); chk("R3 overflow flag", v[3], 1);
        @(negedge clk);
        chk("R2 first word kept", cmd_byte, 8'h10);
        wr(3'd6, 11'h008);
        rd(3'd6, v); chk("R11 overflow cleared", v[3], 0);

        // R7 abort flush
        rxput(8'h11); rxput(8'h22);
        @(negedge clk); eng_abort = 1;
        @(negedge clk); eng_abort = 0;
        rd(3'd3, v); chk("R7 tx flushed", v, 0);
        rd(3'd4, v); chk("R7 rx flushed", v, 0);
        rd(3'd6, v); chk("R7 abort flag", v[5], 1);
        chk("R11 abort_o", abort_o, 1);
        wr(3'd6, 11'h020);
        chk("R11 abort_o cleared", abort_o, 0);

        // R6 receive threshold and R2 receive order
        rxput(8'h5C);
        chk("R6 rx_high thr0 lvl1", rx_high, 1);
        rxput(8'h9D);
        wr(3'd5, 11'h020);
        chk("R6 rx_high thr2 lvl2", rx_high, 0);
        wr(3'd5, 11'h010);
        chk("R6 rx_high thr1 lvl2", rx_high, 1);
        rd(3'd4, v); chk("R2 rx level", v, 2);
        rd(3'd2, v); chk("R2 rx first", v, 11'h05C);
        rd(3'd2, v); chk("R2 rx second", v, 11'h09D);
        // R4 underflow
        rd(3'd2, v); chk("R4 empty read zero", v, 0);
        rd(3'd6, v); chk("R4 underflow flag", v[4], 1);

        // R8 disable waits for idle
        wr(3'd2, 11'h011);
        eng_busy = 1;
        wr(3'd0, 11'h000);
        chk("R10 mode10 off", addr_10bit, 0);
        repeat (3) @(negedge clk);
        chk("R8 en stays while busy", en_status, 1);
        chk("R8 valid while busy", cmd_valid, 1);
        eng_busy = 0;
        repeat (2) @(negedge clk);
        chk("R8 en falls idle", en_status, 0);
        chk("R8 valid gated", cmd_valid, 0);
        rd(3'd3, v); chk("R8 word still queued", v, 1);

        // R9 push while disabled
        wr(3'd2, 11'h055);
        rd(3'd3, v); chk("R9 tx flushed", v, 0);
        rd(3'd6, v); chk("R9 disabled abort flag", v[6], 1);
        chk("R9 abort_o", abort_o, 1);
        wr(3'd6, 11'h078);
        rd(3'd6, v); chk("R11 all flags cleared", v[6:3], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule